// File: doc/BRIEF.md
# PHY Configuration Write Port with Request/Acknowledge Handshake

This block gives host software a path into a small configuration register file inside a storage-card PHY. Software reaches it through one 32-bit control word. It loads a register address and a data byte, then sets a request bit. The block takes the request, waits a configurable number of cycles, and commits the access. It then raises an acknowledge bit in the same word. Software clears the request, and the acknowledge falls. Only after that may the next access begin. A read request follows the same four phases and returns the selected byte in a dedicated field of the control word.

The register file has 64 byte-wide locations. Only a parameter-selected subset is implemented: by default the per-speed-mode input delay settings at 0x00 to 0x08 and the clock and strobe DLL delay settings at 0x0B to 0x0D. The PHY logic reads the stored settings through its own read port.

Top module: `phy_cfg_port`

## Requirements
- R1: After reset the status word reads 0 and every register file location reads 0 on the PHY read port.
- R2: The acknowledge (status bit 26) rises exactly ACK_LAT cycles after the host write that sets a request bit (write request bit 24, read request bit 25). It stays low before that.
- R3: A completed write exchange stores data field bits 15:8 at the register address in bits 5:0. The stored value is visible on the PHY read port from the cycle in which the acknowledge rises.
- R4: The acknowledge stays high while either request bit is set. It falls one cycle after the host write that clears both request bits.
- R5: A completed read exchange places the addressed byte in status bits 23:16. That field keeps its value until the next completed read.
- R6: When both request bits are set, the write is performed and the read data field is left unchanged.
- R7: Locations outside IMPL_MASK read as zero on both read paths, and writes to them have no effect.
- R8: If the request is cleared before the acknowledge rises, no acknowledge is given and the register file is unchanged.
- R9: A host write that arrives while the acknowledge is high does not commit a second access, even if the request bit is still set and the data is new.
- R10: Status bits 24, 25, 15:8 and 5:0 echo the last host write. Status bits 31:27 and 7:6 read zero. Host-written values in bits 26 and 23:16 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| host_we_i | input | 1 | Write strobe for the control word |
| host_wdata_i | input | 32 | Control word value written by the host |
| status_o | output | 32 | Readable control and status word |
| phy_raddr_i | input | 6 | PHY-side register file read address |
| phy_rdata_o | output | 8 | PHY-side register file read data |

## Verification
The bench builds the block with ACK_LAT = 3 and the default IMPL_MASK. A latency of 3 leaves room to drop a request in the middle of the wait and check the abort path, and still lets every cycle of the wait be counted. With the default mask, sweeping all 64 addresses through both write and read exchanges covers implemented and unimplemented locations alike. The expected byte for each location is computed from its address.

// File: rtl/phy_cfg_pkg.sv
package phy_cfg_pkg;
  localparam int ADDR_W    = 6;
  localparam int DATA_W    = 8;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int WR_BIT    = 24;
  localparam int RD_BIT    = 25;
  localparam int ACK_BIT   = 26;
  localparam int RDATA_LSB = 16;
  localparam int WDATA_LSB = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_ACK  = 2'd2
  } hs_state_e;
endpackage

// File: rtl/phy_cfg_hs_fsm.sv
module phy_cfg_hs_fsm
  import phy_cfg_pkg::*;
#(
  parameter int ACK_LAT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  input  logic rd_req_i,
  output logic ack_o,
  output logic wr_commit_o,
  output logic rd_commit_o
);
  localparam int CNT_W = (ACK_LAT < 2) ? 1 : $clog2(ACK_LAT + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ACK_LAT - 1);

  hs_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic req, commit;

  assign req = wr_req_i | rd_req_i;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    commit  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req) begin
        if (ACK_LAT == 1) begin
          commit  = 1'b1;
          state_d = ST_ACK;
        end else begin
          cnt_d   = CNT_W'(1);
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!req) begin
          state_d = ST_IDLE;
        end else if (cnt_q == CNT_LAST) begin
          commit  = 1'b1;
          state_d = ST_ACK;
        end else begin
          cnt_d = cnt_q + CNT_W'(1);
        end
      end
      ST_ACK: if (!req) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // write wins over read when both are requested
  assign wr_commit_o = commit & wr_req_i;
  assign rd_commit_o = commit & ~wr_req_i & rd_req_i;
  assign ack_o       = (state_q == ST_ACK);
endmodule

// File: rtl/phy_cfg_regfile.sv
module phy_cfg_regfile
  import phy_cfg_pkg::*;
#(
  parameter logic [DEPTH-1:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [ADDR_W-1:0] raddr_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_loc
    if (IMPL_MASK[g]) begin : g_impl
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                  mem[g] <= '0;
        else if (we_i && (waddr_i == ADDR_W'(g)))     mem[g] <= wdata_i;
      end
    end else begin : g_hole
      assign mem[g] = '0;
    end
  end

  assign rdata_a_o = mem[raddr_a_i];
  assign rdata_b_o = mem[raddr_b_i];
endmodule

// File: rtl/phy_cfg_port.sv
module phy_cfg_port
  import phy_cfg_pkg::*;
#(
  parameter int               ACK_LAT   = 3,
  parameter logic [DEPTH-1:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        host_we_i,
  input  logic [31:0] host_wdata_i,
  output logic [31:0] status_o,
  input  logic [5:0]  phy_raddr_i,
  output logic [7:0]  phy_rdata_o
);
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q, rf_rdata;
  logic wr_q, rd_q, ack, wr_commit, rd_commit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      wr_q    <= 1'b0;
      rd_q    <= 1'b0;
    end else if (host_we_i) begin
      addr_q  <= host_wdata_i[ADDR_W-1:0];
      wdata_q <= host_wdata_i[WDATA_LSB +: DATA_W];
      wr_q    <= host_wdata_i[WR_BIT];
      rd_q    <= host_wdata_i[RD_BIT];
    end
  end

  phy_cfg_hs_fsm #(.ACK_LAT(ACK_LAT)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_req_i    (wr_q),
    .rd_req_i    (rd_q),
    .ack_o       (ack),
    .wr_commit_o (wr_commit),
    .rd_commit_o (rd_commit)
  );

  phy_cfg_regfile #(.IMPL_MASK(IMPL_MASK)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (wr_commit),
    .waddr_i   (addr_q),
    .wdata_i   (wdata_q),
    .raddr_a_i (addr_q),
    .rdata_a_o (rf_rdata),
    .raddr_b_i (phy_raddr_i),
    .rdata_b_o (phy_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (rd_commit) rdata_q <= rf_rdata;
  end

  assign status_o = {5'b0, ack, rd_q, wr_q, rdata_q, wdata_q, 2'b0, addr_q};
endmodule

// File: rtl/phy_cfg_port_chk.sv
module phy_cfg_port_chk
  import phy_cfg_pkg::*;
#(
  parameter int               ACK_LAT   = 3,
  parameter logic [DEPTH-1:0] IMPL_MASK = 64'h0000_0000_0000_39FF
) (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [31:0] status_o,
  input logic [5:0]  phy_raddr_i,
  input logic [7:0]  phy_rdata_o
);
  logic ack, req;
  logic [3:0] pend_q;

  assign ack = status_o[ACK_BIT];
  assign req = status_o[WR_BIT] | status_o[RD_BIT];

  // cycles a request has been pending without acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              pend_q <= '0;
    else if (!req || ack)     pend_q <= '0;
    else if (pend_q != 4'hF)  pend_q <= pend_q + 4'd1;
  end

  p_ack_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack) |-> (pend_q == 4'(ACK_LAT)));
  p_ack_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && req) |=> ack);
  p_ack_fall_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && !req) |=> !ack);
  p_no_req_no_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ack && !req) |=> !ack);
  p_rdata_stable_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$rose(ack) |-> $stable(status_o[RDATA_LSB +: DATA_W]));
  p_hole_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !IMPL_MASK[phy_raddr_i] |-> (phy_rdata_o == 8'h00));
  p_reserved_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[31:27] == 5'd0) && (status_o[7:6] == 2'd0));
endmodule

bind phy_cfg_port phy_cfg_port_chk #(.ACK_LAT(ACK_LAT), .IMPL_MASK(IMPL_MASK)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .status_o    (status_o),
  .phy_raddr_i (phy_raddr_i),
  .phy_rdata_o (phy_rdata_o)
);

// File: tb/tb_phy_cfg_port.sv
module tb_phy_cfg_port;
  localparam int LAT = 3;
  localparam logic [63:0] MASK = 64'h0000_0000_0000_39FF;
  localparam logic [31:0] WR = 32'h0100_0000;
  localparam logic [31:0] RD = 32'h0200_0000;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0;
  logic [31:0] wd = '0, st;
  logic [5:0] praddr = '0;
  logic [7:0] prdata;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  phy_cfg_port #(.ACK_LAT(LAT), .IMPL_MASK(MASK)) dut (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_wdata_i(wd),
    .status_o(st), .phy_raddr_i(praddr), .phy_rdata_o(prdata));

  function automatic logic [7:0] pat(int a);
    return 8'(((a * 37 + 5) & 8'h7F) | 8'h80);
  endfunction

  function automatic logic [7:0] exp_rf(int a);
    return MASK[a] ? pat(a) : 8'h00;
  endfunction

  function automatic logic [31:0] word(int a, logic [7:0] d);
    return {16'h0, d, 2'b00, 6'(a)};
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // called at a negedge, returns at the negedge after the sampling edge
  task automatic host_wr(logic [31:0] v);
    we = 1'b1; wd = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic phy_peek(int a, logic [7:0] exp, string tag);
    praddr = 6'(a);
    #1 chk(tag, {24'h0, prdata}, {24'h0, exp});
  endtask

  task automatic wr_xchg(int a, logic [7:0] d);
    host_wr(word(a, d));
    host_wr(word(a, d) | WR);
    for (int i = 1; i <= LAT; i++) begin
      @(negedge clk);
      chk("R2 ack timing", {31'h0, st[26]}, {31'h0, i == LAT});
    end
    @(negedge clk);
    chk("R4 ack hold", {31'h0, st[26]}, 32'h1);
    host_wr(word(a, d));
    chk("R4 ack before drop", {31'h0, st[26]}, 32'h1);
    @(negedge clk);
    chk("R4 ack fall", {31'h0, st[26]}, 32'h0);
  endtask

  task automatic rd_xchg(int a, logic [7:0] exp);
    host_wr(word(a, 8'h00) | RD);
    repeat (LAT) @(negedge clk);
    chk("R5 read ack", {31'h0, st[26]}, 32'h1);
    chk("R5 R7 read data", {24'h0, st[23:16]}, {24'h0, exp});
    host_wr(word(a, 8'h00));
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status reset", st, 32'h0);
    for (int a = 0; a < 64; a++) phy_peek(a, 8'h00, "R1 rf reset");
    rst_n = 1'b1;
    @(negedge clk);

    // R10 ignored and echoed bits
    host_wr(32'hFCFF_00C0);
    chk("R10 ignored bits", st, 32'h0);
    host_wr(32'h0000_A53F);
    repeat (4) @(negedge clk);
    chk("R10 echo fields", st, 32'h0000_A53F);

    // R3 R7 write sweep
    for (int a = 0; a < 64; a++) begin
      wr_xchg(a, pat(a));
      phy_peek(a, exp_rf(a), "R3 R7 phy read after write");
    end
    for (int a = 0; a < 64; a++) phy_peek(a, exp_rf(a), "R3 R7 final contents");

    // R5 R7 read sweep
    for (int a = 0; a < 64; a++) rd_xchg(a, exp_rf(a));

    // R5 hold across a write
    rd_xchg(1, pat(1));
    wr_xchg(5, 8'h5A);
    chk("R5 rdata hold", {24'h0, st[23:16]}, {24'h0, pat(1)});

    // R6 both requests: write wins
    host_wr(word(2, 8'h3C) | WR | RD);
    repeat (LAT) @(negedge clk);
    chk("R6 ack", {31'h0, st[26]}, 32'h1);
    chk("R6 rdata untouched", {24'h0, st[23:16]}, {24'h0, pat(1)});
    phy_peek(2, 8'h3C, "R6 write done");
    host_wr(word(2, 8'h3C));
    @(negedge clk);

    // R8 abort before ack
    host_wr(word(3, 8'h11) | WR);
    host_wr(word(3, 8'h11));
    for (int i = 0; i < 6; i++) begin
      chk("R8 no ack", {31'h0, st[26]}, 32'h0);
      @(negedge clk);
    end
    phy_peek(3, pat(3), "R8 rf unchanged");

    // R9 no second commit while ack high
    wr_xchg(4, 8'h22);
    host_wr(word(4, 8'h22) | WR);
    repeat (LAT) @(negedge clk);
    host_wr(word(4, 8'h33) | WR);
    repeat (LAT + 2) @(negedge clk);
    chk("R9 ack still high", {31'h0, st[26]}, 32'h1);
    phy_peek(4, 8'h22, "R9 rf not rewritten");
    host_wr(word(4, 8'h33));
    @(negedge clk);
    chk("R4 R9 ack fall", {31'h0, st[26]}, 32'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule